// File: doc/BRIEF.md
# Palette Lookup Unit with Cursor Overlay

The block turns an 8-bit pixel index into a 24-bit RGB colour through a 256-entry palette. It also replaces the palette colour with one of two cursor colours when the cursor overlay is on. Software loads the palette through a small register window on a 32-bit bus. Only the top byte of each bus word carries data.

A single internal address register is shared by all ports. Writing the address port selects a palette entry or an internal register. Writes and reads on the colour-data port then step through red, green and blue. After blue, the address moves on to the next entry, so a whole block of entries loads in one burst.

The two cursor colours sit behind an overlay-data port: address 1 holds the background colour and address 3 holds the foreground colour. A control register at address 6 turns the overlay on.

Top module: `palette_dac`

## Requirements
- R1: While reset is low and right after it is released: the address register is 0, the sub-step is red, the control register is 0, every palette and overlay colour is 0, and `rgbOut` is 0.
- R2: A write with `busSel`=0 loads the address register from bus bits 31:24 and returns the sub-step to red, even after a partial R/G/B sequence.
- R3: A write with `busSel`=1 stores bits 31:24 as the current component of palette entry `address`. The components are taken in the order red (rgb bits 23:16), green (15:8), blue (7:0), one write each.
- R4: Each write or read on ports 1 or 2 advances the sub-step. After blue, the sub-step returns to red and the address increments, wrapping from 255 to 0.
- R5: `busRdData` bits 31:24 hold the selected byte and bits 23:0 are 0. The byte depends on `busSel`:
  - 0 returns the address.
  - 1 returns the current palette component.
  - 2 returns the current overlay component.
  - 3 returns the control register.
  A read on ports 1 or 2 steps the sub-step as in R4. When write and read are both asserted, the write wins.
- R6: A write with `busSel`=2 updates the background overlay colour at address 1 or the foreground overlay colour at address 3, component by component. At any other address it changes nothing but still steps the sub-step. Overlay reads at other addresses return 0.
- R7: A write with `busSel`=3 updates the control register only at address 6. The overlay is enabled only when control bits 1:0 are both 1. Control reads at other addresses return 0.
- R8: `rgbOut` is registered: one clock after `pixIndex` is sampled, it shows that palette entry's colour as it stood before that edge.
- R9: With the overlay enabled and `cursorOn` high, `rgbOut` shows the foreground overlay colour if `cursorFg` is 1 and the background overlay colour if it is 0. This replaces the palette colour.
- R10: Bus write bits 23:0 have no effect on any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busSel | input | 2 | Port: 0 address, 1 colour data, 2 overlay data, 3 control |
| busWrData | input | 32 | Write word, data in bits 31:24 |
| busRdData | output | 32 | Read word, data in bits 31:24 |
| pixIndex | input | 8 | Pixel palette index |
| cursorOn | input | 1 | Cursor mask active for this pixel |
| cursorFg | input | 1 | Cursor pixel selects the foreground colour (1) or the background colour (0) |
| rgbOut | output | 24 | Registered colour, R in 23:16 |

## Verification
The hardest state to reach is the auto-increment wrap from entry 255 to entry 0 partway through a burst. It is reached by loading address 255 and writing four components in a row, so the fourth write lands in entry 0's red. The abandoned partial sequence is the other hard case. The stimulus writes only red, reloads the same address, and writes a full triple, then confirms through the pixel path that red was overwritten. The overlay tests first write at non-overlay and non-control addresses, then check that the colour output still shows the palette.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;
  localparam int INDEX_W = 8;
  localparam int CHAN_W  = 8;
  localparam int RGB_W   = 3 * CHAN_W;
  localparam int ENTRIES = 1 << INDEX_W;

  localparam logic [INDEX_W-1:0] OVL_BG_ADDR = 8'd1;
  localparam logic [INDEX_W-1:0] OVL_FG_ADDR = 8'd3;
  localparam logic [INDEX_W-1:0] CTL_ADDR    = 8'd6;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAL  = 2'd1,
    SEL_OVL  = 2'd2,
    SEL_CTL  = 2'd3
  } portSel_e;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  typedef struct packed {
    logic               palWr;
    logic               ovlWr;
    logic               ovlFg;
    logic               ctlWr;
    logic [INDEX_W-1:0] entry;
    comp_e              comp;
    logic [CHAN_W-1:0]  wrByte;
  } dacStrobe_t;

  function automatic logic [CHAN_W-1:0] pickComp(input logic [RGB_W-1:0] c, input comp_e k);
    case (k)
      COMP_RED:   return c[3*CHAN_W-1 -: CHAN_W];
      COMP_GREEN: return c[2*CHAN_W-1 -: CHAN_W];
      default:    return c[CHAN_W-1 -: CHAN_W];
    endcase
  endfunction
endpackage

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import palette_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  portSel_e          sel,
  input  logic [CHAN_W-1:0] wrByte,
  output dacStrobe_t        stb
);
  logic [INDEX_W-1:0] addrQ;
  comp_e              compQ;
  logic               dataPort;
  logic               advance;

  assign dataPort = (sel == SEL_PAL) || (sel == SEL_OVL);
  assign advance  = dataPort && (wrEn || rdEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      compQ <= COMP_RED;
    end else if (wrEn && sel == SEL_ADDR) begin
      addrQ <= wrByte;
      compQ <= COMP_RED;
    end else if (advance) begin
      if (compQ == COMP_BLUE) begin
        compQ <= COMP_RED;
        addrQ <= addrQ + 1'b1;
      end else begin
        compQ <= comp_e'(compQ + 2'd1);
      end
    end
  end

  always_comb begin
    stb.palWr  = wrEn && sel == SEL_PAL;
    stb.ovlWr  = wrEn && sel == SEL_OVL && (addrQ == OVL_BG_ADDR || addrQ == OVL_FG_ADDR);
    stb.ovlFg  = addrQ == OVL_FG_ADDR;
    stb.ctlWr  = wrEn && sel == SEL_CTL && addrQ == CTL_ADDR;
    stb.entry  = addrQ;
    stb.comp   = compQ;
    stb.wrByte = wrByte;
  end
endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import palette_dac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dacStrobe_t         stb,
  input  portSel_e           sel,
  input  logic [INDEX_W-1:0] pixIndex,
  input  logic               cursorOn,
  input  logic               cursorFg,
  output logic [RGB_W-1:0]   rgbOut,
  output logic [CHAN_W-1:0]  rdByte
);
  logic [RGB_W-1:0]  palMem [ENTRIES];
  logic [RGB_W-1:0]  ovlColor [2];
  logic [CHAN_W-1:0] ctlReg;
  logic              ovlEnable;
  int                compLsb;

  assign ovlEnable = &ctlReg[1:0];
  assign compLsb   = (2 - int'(stb.comp)) * CHAN_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) palMem[i] <= '0;
    end else if (stb.palWr) begin
      palMem[stb.entry][compLsb +: CHAN_W] <= stb.wrByte;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gOvl
    always_ff @(posedge clk) begin
      if (!rstN) ovlColor[g] <= '0;
      else if (stb.ovlWr && (stb.ovlFg == (g == 1)))
        ovlColor[g][compLsb +: CHAN_W] <= stb.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlReg <= '0;
    else if (stb.ctlWr) ctlReg <= stb.wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rgbOut <= '0;
    else if (ovlEnable && cursorOn) rgbOut <= ovlColor[cursorFg];
    else rgbOut <= palMem[pixIndex];
  end

  always_comb begin
    rdByte = '0;
    case (sel)
      SEL_ADDR: rdByte = stb.entry;
      SEL_PAL:  rdByte = pickComp(palMem[stb.entry], stb.comp);
      SEL_OVL:  if (stb.entry == OVL_BG_ADDR || stb.entry == OVL_FG_ADDR)
                  rdByte = pickComp(ovlColor[stb.ovlFg], stb.comp);
      default:  if (stb.entry == CTL_ADDR) rdByte = ctlReg;
    endcase
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_dac_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [1:0]         busSel,
  input  logic [BUS_W-1:0]   busWrData,
  output logic [BUS_W-1:0]   busRdData,
  input  logic [INDEX_W-1:0] pixIndex,
  input  logic               cursorOn,
  input  logic               cursorFg,
  output logic [RGB_W-1:0]   rgbOut
);
  localparam int PAD_W = BUS_W - CHAN_W;

  dacStrobe_t        stb;
  logic [CHAN_W-1:0] rdByte;
  logic              unusedLowBits;

  assign unusedLowBits = ^busWrData[PAD_W-1:0];

  dac_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (busWrEn),
    .rdEn   (busRdEn),
    .sel    (portSel_e'(busSel)),
    .wrByte (busWrData[BUS_W-1 -: CHAN_W]),
    .stb    (stb)
  );

  dac_datapath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sel      (portSel_e'(busSel)),
    .pixIndex (pixIndex),
    .cursorOn (cursorOn),
    .cursorFg (cursorFg),
    .rgbOut   (rgbOut),
    .rdByte   (rdByte)
  );

  assign busRdData = {rdByte, {PAD_W{1'b0}}};
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [1:0]  busSel,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic [7:0]  pixIndex,
  input logic        cursorOn,
  input logic        cursorFg,
  input logic [23:0] rgbOut
);
  AST_RESET_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rgbOut == 24'd0); // R1

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSel == 2'd0) |=>
      (busSel != 2'd0 || busWrEn || busRdData[31:24] == $past(busWrData[31:24]))); // R2

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[23:0] == 24'd0); // R5

  AST_RGB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busWrEn) && $stable(pixIndex) && $stable(cursorOn) && $stable(cursorFg))
      |=> $stable(rgbOut)); // R8
endmodule

bind palette_dac palette_dac_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busSel    (busSel),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .pixIndex  (pixIndex),
  .cursorOn  (cursorOn),
  .cursorFg  (cursorFg),
  .rgbOut    (rgbOut)
);

// File: tb/palette_dac_test.sv
`timescale 1ns/100ps
module palette_dac_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [1:0]  busSel = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic [7:0]  pixIndex = 0;
  logic        cursorOn = 0, cursorFg = 0;
  logic [23:0] rgbOut;

  int checks = 0, errors = 0;
  bit running = 0;

  palette_dac uut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  int mPal [256][3];
  int mOvl [2][3];
  int mAddr, mComp, mCtl, mRgb;

  function automatic int packRgb(int r, int g, int b);
    return (r << 16) | (g << 8) | b;
  endfunction

  task automatic stepModel();
    if (mComp == 2) begin mComp = 0; mAddr = (mAddr + 1) % 256; end
    else mComp++;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mComp = 0; mCtl = 0; mRgb = 0;
      for (int i = 0; i < 256; i++) for (int k = 0; k < 3; k++) mPal[i][k] = 0;
      for (int i = 0; i < 2; i++) for (int k = 0; k < 3; k++) mOvl[i][k] = 0;
    end else begin
      int b;
      b = int'(busWrData[31:24]);
      if ((mCtl & 3) == 3 && cursorOn)
        mRgb = packRgb(mOvl[cursorFg][0], mOvl[cursorFg][1], mOvl[cursorFg][2]);
      else
        mRgb = packRgb(mPal[pixIndex][0], mPal[pixIndex][1], mPal[pixIndex][2]);
      if (busWrEn) begin
        case (busSel)
          2'd0: begin mAddr = b; mComp = 0; end
          2'd1: begin mPal[mAddr][mComp] = b; stepModel(); end
          2'd2: begin
            if (mAddr == 1) mOvl[0][mComp] = b;
            if (mAddr == 3) mOvl[1][mComp] = b;
            stepModel();
          end
          default: if (mAddr == 6) mCtl = b;
        endcase
      end else if (busRdEn && (busSel == 2'd1 || busSel == 2'd2)) begin
        stepModel();
      end
    end
  end

  function automatic int modelRd();
    case (busSel)
      2'd0: return mAddr;
      2'd1: return mPal[mAddr][mComp];
      2'd2: return (mAddr == 1) ? mOvl[0][mComp] : (mAddr == 3) ? mOvl[1][mComp] : 0;
      default: return (mAddr == 6) ? mCtl : 0;
    endcase
  endfunction

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk);
    #1;
    if (running) begin
      checks++;
      if (rgbOut !== 24'(mRgb)) begin
        errors++;
        $display("FAIL R8/R9 cycle rgbOut actual=%h expected=%h", rgbOut, 24'(mRgb));
      end
      checks++;
      if (busRdData !== {8'(modelRd()), 24'd0}) begin
        errors++;
        $display("FAIL R5 cycle busRdData actual=%h expected=%h", busRdData, {8'(modelRd()), 24'd0});
      end
    end
  end

  task automatic busOp(input logic [1:0] sel, input bit wr, input bit rd, input logic [7:0] val);
    @(negedge clk);
    busSel = sel; busWrEn = wr; busRdEn = rd;
    busWrData = {val, 24'hABCDEF};
  endtask

  task automatic pixel(input logic [7:0] idx, input bit on, input bit fg);
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
    pixIndex = idx; cursorOn = on; cursorFg = fg;
  endtask

  task automatic expectRd(input logic [7:0] exp, input string tag);
    #1.5;
    checks++;
    if (busRdData[31:24] !== exp) begin
      errors++;
      $display("FAIL %s busRdData actual=%h expected=%h", tag, busRdData[31:24], exp);
    end
  endtask

  task automatic expectRgb(input logic [23:0] exp, input string tag);
    @(negedge clk);
    #1.5;
    checks++;
    if (rgbOut !== exp) begin
      errors++;
      $display("FAIL %s rgbOut actual=%h expected=%h", tag, rgbOut, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    running = 1;
    busOp(0, 0, 0, 0);
    expectRd(8'h00, "R1 address after reset");
    pixel(8'h42, 0, 0);
    expectRgb(24'h0, "R1 palette after reset");

    // R3 R10: component writes carry garbage in low bits
    busOp(0, 1, 0, 8'h10);
    busOp(1, 1, 0, 8'h12);
    busOp(1, 1, 0, 8'h34);
    busOp(1, 1, 0, 8'h56);
    busOp(1, 1, 0, 8'h78);
    busOp(1, 1, 0, 8'h9A);
    busOp(1, 1, 0, 8'hBC);
    pixel(8'h10, 0, 0);
    expectRgb(24'h123456, "R3 R10 entry 0x10");
    pixel(8'h11, 0, 0);
    expectRgb(24'h789ABC, "R4 next entry");

    // R5 readback with auto-increment
    busOp(0, 1, 0, 8'h10);
    busOp(1, 0, 1, 0); expectRd(8'h12, "R5 read red");
    busOp(1, 0, 1, 0); expectRd(8'h34, "R5 read green");
    busOp(1, 0, 1, 0); expectRd(8'h56, "R5 read blue");
    busOp(0, 0, 0, 0); expectRd(8'h11, "R4 address after read triple");

    // R4 wrap from 255 to 0
    busOp(0, 1, 0, 8'hFF);
    busOp(1, 1, 0, 8'hA1);
    busOp(1, 1, 0, 8'hA2);
    busOp(1, 1, 0, 8'hA3);
    busOp(0, 0, 0, 0); expectRd(8'h00, "R4 wrap address");
    busOp(1, 1, 0, 8'hB1);
    pixel(8'hFF, 0, 0);
    expectRgb(24'hA1A2A3, "R4 entry 255");
    pixel(8'h00, 0, 0);
    expectRgb(24'hB10000, "R4 wrapped into entry 0");

    // R2 abandoned partial sequence
    busOp(0, 1, 0, 8'h20);
    busOp(1, 1, 0, 8'h77);
    busOp(0, 1, 0, 8'h20);
    busOp(1, 1, 0, 8'h01);
    busOp(1, 1, 0, 8'h02);
    busOp(1, 1, 0, 8'h03);
    pixel(8'h20, 0, 0);
    expectRgb(24'h010203, "R2 substep reset");

    // R6 overlay colours
    busOp(0, 1, 0, 8'h01);
    busOp(2, 1, 0, 8'h11); busOp(2, 1, 0, 8'h22); busOp(2, 1, 0, 8'h33);
    busOp(0, 1, 0, 8'h03);
    busOp(2, 1, 0, 8'h44); busOp(2, 1, 0, 8'h55); busOp(2, 1, 0, 8'h66);
    busOp(0, 1, 0, 8'h05);
    busOp(2, 1, 0, 8'h99);
    busOp(0, 1, 0, 8'h05);
    busOp(2, 0, 0, 0); expectRd(8'h00, "R6 non-overlay address reads 0");
    busOp(0, 1, 0, 8'h01);
    busOp(2, 0, 1, 0); expectRd(8'h11, "R6 background red");
    busOp(0, 1, 0, 8'h03);
    busOp(2, 0, 1, 0); expectRd(8'h44, "R6 foreground red");

    // R7 control register
    busOp(0, 1, 0, 8'h07);
    busOp(3, 1, 0, 8'h03);
    busOp(3, 0, 0, 0); expectRd(8'h00, "R7 control at wrong address");
    pixel(8'h10, 1, 1);
    expectRgb(24'h123456, "R7 overlay still off");
    busOp(0, 1, 0, 8'h06);
    busOp(3, 1, 0, 8'h01);
    pixel(8'h10, 1, 1);
    expectRgb(24'h123456, "R7 one bit does not enable");
    busOp(0, 1, 0, 8'h06);
    busOp(3, 1, 0, 8'h03);
    busOp(3, 0, 0, 0); expectRd(8'h03, "R7 control readback");

    // R9 overlay mixing
    pixel(8'h10, 1, 1);
    expectRgb(24'h445566, "R9 foreground");
    pixel(8'h10, 1, 0);
    expectRgb(24'h112233, "R9 background");
    pixel(8'h10, 0, 1);
    expectRgb(24'h123456, "R9 cursor off shows palette");

    // R8 random pixel sweep with interleaved writes, checked each cycle
    for (int n = 0; n < 400; n++) begin
      if (n % 7 == 0) busOp(2'($urandom_range(0, 3)), 1, 0, 8'($urandom));
      else if (n % 5 == 0) busOp(2'($urandom_range(1, 2)), 0, 1, 0);
      else pixel(8'($urandom), 1'($urandom), 1'($urandom));
    end
    pixel(0, 0, 0);
    repeat (3) @(negedge clk);
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule